// File: doc/BRIEF.md
# Per-Port Token Bucket Rate Limiter

This block paces the traffic leaving one output port. It keeps a signed token balance that is refilled by a fixed amount on every clock. Every packet that starts on the port is charged for its framing overhead and for its payload, which is counted in 8-byte words. The block raises a send-permit output while the balance is non-negative. The scheduler ahead of the block starts a new packet only while that permit is high.

The block holds three configuration values. The overhead cost and the balance ceiling are written in units of 256 tokens. The word cost is written in single tokens. Software can therefore set a packet-rate limit by writing a word cost of zero, or a bit-rate limit by deriving all three values from tokens-per-bit. Each configuration write carries a port number, and only writes aimed at this instance's own port are taken. The balance never rises above the scaled ceiling, so the ceiling sets the largest burst the port may send after an idle period.

Top module: `port_rate_limiter`

## Requirements
- R1: After reset the balance equals the reset ceiling times 256, the overhead cost and word cost hold their reset parameter values, and sendOk is 1.
- R2: sendOk is 1 exactly when the balance is greater than or equal to zero. A balance of exactly zero still permits sending.
- R3: On a clock edge where pktStart is 1, the balance is reduced by overhead cost × 256 + pktWords × word cost, in addition to the refill on that edge.
- R4: Packets started on consecutive cycles are each charged in full. Their charges accumulate in the balance.
- R5: On every clock edge the balance gains REFILL tokens (default 16).
- R6: The balance after any edge is at most the ceiling times 256, as the ceiling was before that edge. Refill beyond that value is discarded.
- R7: A configuration write with cfgWe = 1 and cfgPort equal to PORT_ID (default 5) loads overhead cost, word cost and ceiling on that edge. The new values take effect from the next edge.
- R8: A configuration write whose cfgPort differs from PORT_ID changes none of the three configuration values.
- R9: After the ceiling is lowered, the balance is clamped to the new ceiling times 256 on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfgWe | input | 1 | Configuration write strobe |
| cfgPort | input | PORT_W | Port number the write is aimed at |
| cfgPktCost | input | COST_W | Overhead cost per packet, in units of 256 tokens |
| cfgWordCost | input | WCOST_W | Cost per 8-byte payload word, in tokens |
| cfgLimit | input | LIMIT_W | Balance ceiling, in units of 256 tokens |
| pktStart | input | 1 | One-cycle strobe marking the start of a packet |
| pktWords | input | WCNT_W | Payload length in words, valid with pktStart |
| sendOk | output | 1 | Send permit: balance is non-negative |

## Verification
The assertions rely on the scheduler starting a packet only while sendOk is high. Under that rule the balance stays well inside the accumulator range, and the refill and charge arithmetic can never wrap. The bench keeps to this rule: every packet is issued at a falling edge where the permit has already been seen high, and back-to-back sends are issued only while the permit stays high. The bench also waits long enough between scenarios for the balance to return to its ceiling, so each expected blocking count can be derived from a full bucket.

// File: rtl/prl_pkg.sv
package prl_pkg;
  // Strobes handed from control to datapath each cycle
  typedef struct packed {
    logic charge;   // apply packet charge this edge
    logic cfgLoad;  // load configuration this edge
  } prlStrobes_t;
endpackage

// File: rtl/prl_ctrl.sv
module prl_ctrl
  import prl_pkg::*;
#(
  parameter int PORT_W  = 6,
  parameter int PORT_ID = 5
) (
  input  logic              cfgWe,
  input  logic [PORT_W-1:0] cfgPort,
  input  logic              pktStart,
  input  logic              balanceNeg,
  output prlStrobes_t       strobes,
  output logic              sendOk
);
  localparam logic [PORT_W-1:0] OWN_PORT = PORT_W'(PORT_ID);

  always_comb begin
    strobes.charge  = pktStart;
    strobes.cfgLoad = cfgWe && (cfgPort == OWN_PORT);
    sendOk          = !balanceNeg;
  end
endmodule

// File: rtl/prl_datapath.sv
module prl_datapath
  import prl_pkg::*;
#(
  parameter int COST_W        = 12,
  parameter int WCOST_W       = 12,
  parameter int LIMIT_W       = 12,
  parameter int WCNT_W        = 8,
  parameter int ACC_W         = 23,
  parameter int REFILL        = 16,
  parameter int RST_PKT_COST  = 2,
  parameter int RST_WORD_COST = 64,
  parameter int RST_LIMIT     = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  prlStrobes_t              strobes,
  input  logic [COST_W-1:0]        cfgPktCost,
  input  logic [WCOST_W-1:0]       cfgWordCost,
  input  logic [LIMIT_W-1:0]       cfgLimit,
  input  logic [WCNT_W-1:0]        pktWords,
  output logic signed [ACC_W-1:0]  balance,
  output logic signed [ACC_W-1:0]  limitScaled,
  output logic [COST_W-1:0]        pktCostQ,
  output logic [WCOST_W-1:0]       wordCostQ,
  output logic [LIMIT_W-1:0]       limitQ,
  output logic                     balanceNeg
);
  localparam logic signed [ACC_W-1:0] REFILL_S = ACC_W'(REFILL);
  localparam logic signed [ACC_W-1:0] RST_BAL  = ACC_W'(RST_LIMIT) <<< 8;

  logic signed [ACC_W-1:0] pktPart;
  logic signed [ACC_W-1:0] wordPart;
  logic signed [ACC_W-1:0] charge;
  logic signed [ACC_W-1:0] sumNext;
  logic signed [ACC_W-1:0] balNext;

  always_comb begin
    limitScaled = $signed({{(ACC_W-LIMIT_W-8){1'b0}}, limitQ, 8'h00});
    pktPart     = $signed({{(ACC_W-COST_W-8){1'b0}}, pktCostQ, 8'h00});
    wordPart    = $signed({{(ACC_W-WCOST_W){1'b0}}, wordCostQ})
                * $signed({{(ACC_W-WCNT_W){1'b0}}, pktWords});
    charge      = strobes.charge ? (pktPart + wordPart) : '0;
    sumNext     = balance + REFILL_S - charge;
    balNext     = (sumNext > limitScaled) ? limitScaled : sumNext;
    balanceNeg  = balance[ACC_W-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      balance   <= RST_BAL;
      pktCostQ  <= COST_W'(RST_PKT_COST);
      wordCostQ <= WCOST_W'(RST_WORD_COST);
      limitQ    <= LIMIT_W'(RST_LIMIT);
    end else begin
      balance <= balNext;
      if (strobes.cfgLoad) begin
        pktCostQ  <= cfgPktCost;
        wordCostQ <= cfgWordCost;
        limitQ    <= cfgLimit;
      end
    end
  end
endmodule

// File: rtl/port_rate_limiter.sv
module port_rate_limiter
  import prl_pkg::*;
#(
  parameter int PORT_W        = 6,
  parameter int PORT_ID       = 5,
  parameter int COST_W        = 12,
  parameter int WCOST_W       = 12,
  parameter int LIMIT_W       = 12,
  parameter int WCNT_W        = 8,
  parameter int REFILL        = 16,
  parameter int RST_PKT_COST  = 2,
  parameter int RST_WORD_COST = 64,
  parameter int RST_LIMIT     = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfgWe,
  input  logic [PORT_W-1:0]  cfgPort,
  input  logic [COST_W-1:0]  cfgPktCost,
  input  logic [WCOST_W-1:0] cfgWordCost,
  input  logic [LIMIT_W-1:0] cfgLimit,
  input  logic               pktStart,
  input  logic [WCNT_W-1:0]  pktWords,
  output logic               sendOk
);
  // Widths derived so the balance can never wrap under legal use
  localparam int PKT_SW   = COST_W + 8;
  localparam int WORD_SW  = WCOST_W + WCNT_W;
  localparam int CHARGE_W = ((PKT_SW > WORD_SW) ? PKT_SW : WORD_SW) + 1;
  localparam int LIM_SW   = LIMIT_W + 8;
  localparam int ACC_W    = ((LIM_SW > CHARGE_W) ? LIM_SW : CHARGE_W) + 2;

  prlStrobes_t              strobes;
  logic                     balanceNeg;
  logic signed [ACC_W-1:0]  balance;
  logic signed [ACC_W-1:0]  limitScaled;
  logic [COST_W-1:0]        pktCostQ;
  logic [WCOST_W-1:0]       wordCostQ;
  logic [LIMIT_W-1:0]       limitQ;

  prl_ctrl #(
    .PORT_W (PORT_W),
    .PORT_ID(PORT_ID)
  ) u_ctrl (
    .cfgWe     (cfgWe),
    .cfgPort   (cfgPort),
    .pktStart  (pktStart),
    .balanceNeg(balanceNeg),
    .strobes   (strobes),
    .sendOk    (sendOk)
  );

  prl_datapath #(
    .COST_W       (COST_W),
    .WCOST_W      (WCOST_W),
    .LIMIT_W      (LIMIT_W),
    .WCNT_W       (WCNT_W),
    .ACC_W        (ACC_W),
    .REFILL       (REFILL),
    .RST_PKT_COST (RST_PKT_COST),
    .RST_WORD_COST(RST_WORD_COST),
    .RST_LIMIT    (RST_LIMIT)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strobes    (strobes),
    .cfgPktCost (cfgPktCost),
    .cfgWordCost(cfgWordCost),
    .cfgLimit   (cfgLimit),
    .pktWords   (pktWords),
    .balance    (balance),
    .limitScaled(limitScaled),
    .pktCostQ   (pktCostQ),
    .wordCostQ  (wordCostQ),
    .limitQ     (limitQ),
    .balanceNeg (balanceNeg)
  );
endmodule

// File: rtl/prl_checker.sv
module prl_checker #(
  parameter int PORT_W  = 6,
  parameter int PORT_ID = 5,
  parameter int COST_W  = 12,
  parameter int WCOST_W = 12,
  parameter int LIMIT_W = 12,
  parameter int ACC_W   = 23,
  parameter int REFILL  = 16
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     cfgWe,
  input logic [PORT_W-1:0]        cfgPort,
  input logic                     pktStart,
  input logic                     sendOk,
  input logic signed [ACC_W-1:0]  balance,
  input logic signed [ACC_W-1:0]  limitScaled,
  input logic [COST_W-1:0]        pktCostQ,
  input logic [WCOST_W-1:0]       wordCostQ,
  input logic [LIMIT_W-1:0]       limitQ
);
  localparam logic signed [ACC_W-1:0] REF_S = ACC_W'(REFILL);
  localparam logic signed [ACC_W-1:0] UNIT  = ACC_W'(256);
  localparam logic [PORT_W-1:0] OWN_PORT    = PORT_W'(PORT_ID);

  AST_START_NEEDS_PERMIT: assert property (@(posedge clk) disable iff (rst)
    pktStart |-> sendOk); // R2

  AST_NO_OVERFILL: assert property (@(posedge clk) disable iff (rst)
    balance <= $past(limitScaled)); // R6

  AST_REFILL_STEP: assert property (@(posedge clk) disable iff (rst)
    (!pktStart && (balance + REF_S <= limitScaled)) |=> (balance == $past(balance) + REF_S)); // R5

  AST_CHARGE_LOWERS: assert property (@(posedge clk) disable iff (rst)
    (pktStart && (pktCostQ != '0)) |=> (balance <= $past(balance) + REF_S - UNIT)); // R3

  AST_FOREIGN_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (cfgWe && (cfgPort != OWN_PORT)) |=> ($stable(pktCostQ) && $stable(wordCostQ) && $stable(limitQ))); // R8
endmodule

bind port_rate_limiter prl_checker #(
  .PORT_W (PORT_W),
  .PORT_ID(PORT_ID),
  .COST_W (COST_W),
  .WCOST_W(WCOST_W),
  .LIMIT_W(LIMIT_W),
  .ACC_W  (ACC_W),
  .REFILL (REFILL)
) u_prl_checker (
  .clk        (clk),
  .rst        (rst),
  .cfgWe      (cfgWe),
  .cfgPort    (cfgPort),
  .pktStart   (pktStart),
  .sendOk     (sendOk),
  .balance    (balance),
  .limitScaled(limitScaled),
  .pktCostQ   (pktCostQ),
  .wordCostQ  (wordCostQ),
  .limitQ     (limitQ)
);

// File: tb/port_rate_limiter_bench.sv
`timescale 1ns/1ps
module port_rate_limiter_bench;
  localparam int PORT_W  = 6;
  localparam int COST_W  = 12;
  localparam int WCOST_W = 12;
  localparam int LIMIT_W = 12;
  localparam int WCNT_W  = 8;
  localparam int OWN     = 5;
  localparam int OTHER   = 6;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               cfgWe = 1'b0;
  logic [PORT_W-1:0]  cfgPort = '0;
  logic [COST_W-1:0]  cfgPktCost = '0;
  logic [WCOST_W-1:0] cfgWordCost = '0;
  logic [LIMIT_W-1:0] cfgLimit = '0;
  logic               pktStart = 1'b0;
  logic [WCNT_W-1:0]  pktWords = '0;
  logic               sendOk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  port_rate_limiter u_port_rate_limiter (
    .clk(clk), .rst(rst), .cfgWe(cfgWe), .cfgPort(cfgPort),
    .cfgPktCost(cfgPktCost), .cfgWordCost(cfgWordCost), .cfgLimit(cfgLimit),
    .pktStart(pktStart), .pktWords(pktWords), .sendOk(sendOk)
  );

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeCfg(input int port, input int pc, input int wc, input int lim);
    cfgWe = 1'b1; cfgPort = PORT_W'(port);
    cfgPktCost = COST_W'(pc); cfgWordCost = WCOST_W'(wc); cfgLimit = LIMIT_W'(lim);
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  // Issue one packet at the current falling edge, then count the falling
  // edges on which sendOk is low until it returns high.
  task automatic sendMeasure(input int words, output int lows);
    pktStart = 1'b1; pktWords = WCNT_W'(words);
    @(negedge clk);
    pktStart = 1'b0;
    lows = 0;
    while (!sendOk && lows < 4000) begin
      lows++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    int lows;
    rst = 1'b1; idle(4); rst = 1'b0;
    check("R1 permit after reset", int'(sendOk), 1);
    lows = 0;
    repeat (50) begin @(negedge clk); if (!sendOk) lows++; end
    check("R5 idle keeps permit", lows, 0);
  endtask

  task automatic t_single();
    int lows;
    // 1024 + 16 - (2*256 + 10*64) = -112 -> 7 refills of 16
    sendMeasure(10, lows);
    check("R3 single packet block cycles", lows, 7);
    idle(100);
  endtask

  task automatic t_burst();
    int lows;
    // 1024+16-512=528, 528+16-512=32, 32+16-512=-464 -> 29
    sendMeasure(0, lows); check("R4 burst first", lows, 0);
    sendMeasure(0, lows); check("R4 burst second", lows, 0);
    sendMeasure(0, lows); check("R4 burst third", lows, 29);
    idle(100);
  endtask

  task automatic t_zeroBoundary();
    int lows;
    writeCfg(OWN, 4, 16, 4);
    idle(100);
    // 1024 + 16 - (1024 + 16) = 0 -> still permitted
    sendMeasure(1, lows);
    check("R2 R6 R7 balance exactly zero", lows, 0);
    idle(100);
  endtask

  task automatic t_foreign();
    int lows;
    writeCfg(OTHER, 100, 0, 1);
    idle(100);
    // cost 4 kept: 1024 + 16 - 1024 = 16
    sendMeasure(0, lows);
    check("R8 foreign write ignored", lows, 0);
    idle(100);
  endtask

  task automatic t_lowerLimit();
    int lows;
    writeCfg(OWN, 4, 16, 1);
    idle(100);
    // clamped to 256: 256 + 16 - 1024 = -752 -> 47
    sendMeasure(0, lows);
    check("R9 lowered ceiling clamps", lows, 47);
    idle(100);
  endtask

  task automatic t_bitRate();
    int lows;
    writeCfg(OWN, 1, 128, 4);
    idle(100);
    // 1024+16-(256+640)=144 ; 144+16-(256+1024)=-1120 -> 70
    sendMeasure(5, lows); check("R3 word cost five words", lows, 0);
    sendMeasure(8, lows); check("R4 R3 word cost eight words", lows, 70);
    idle(100);
  endtask

  task automatic t_maxWords();
    int lows;
    writeCfg(OWN, 0, 1, 4);
    idle(100);
    // 1024 + 16 - 255 = 785
    sendMeasure(255, lows);
    check("R3 max word count", lows, 0);
    idle(10);
  endtask

  initial begin
    idle(1);
    t_reset();
    t_single();
    t_burst();
    t_zeroBoundary();
    t_foreign();
    t_lowerLimit();
    t_bitRate();
    t_maxWords();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule